// File: doc/BRIEF.md
# MSI Capture Ring Controller

This block takes message-signalled interrupt writes arriving on an inbound message port and records each one as a 16-byte entry in a circular buffer held in system memory. Each message becomes a single memory write through a request/acknowledge master. Only one write is in flight at a time. The block advances its write offset when the write is acknowledged, and it holds a level interrupt high while unread entries remain.

Software sets up the block through a small word-addressed register port. It writes a 64-bit buffer base as two 32-bit halves and sets the control word. It then drains entries by moving the read offset forward in steps of 16 until it equals the write offset. The ring size can be 32, 64, 128 or 256 KB. When the ring fills, the block can either hold off the sender or drop the message and raise a sticky flag.

Top module: `msi_ring_ctrl`

## Requirements
- R1: After reset, the control word, read offset and write offset all read as zero, `irq` is low and `mem_req` is low.
- R2: Register word addresses are: 0 for control, 3 for base high half, 4 for base low half, 5 for read offset and 6 for write offset. The base halves read back as written. Control fields are: bit 0 enable, bit 1 full detection, bit 3 interrupt enable, bit 4 stop-on-full, bits 9:8 size select, and bit 16 sticky overflow (read-only, cleared by writing 1).
- R3: An accepted message (`msg_valid` and `msg_ready` high at a clock edge) produces `mem_req` with `mem_addr` equal to base plus write offset. `mem_wdata` carries the message word in bits 31:0, with byte k of the record in bits 8k+7:8k, and zero in bits 127:32. The request and its data stay stable until `mem_ack`, and no second message is accepted meanwhile.
- R4: On the acknowledged edge, the write offset advances by 16. It wraps to zero at the ring size 2^(15+s) bytes, where s is the size select.
- R5: `irq` is high exactly when enable and interrupt enable are set and the read offset differs from the write offset. Writing a read offset equal to the write offset lowers it.
- R6: A value written to the read offset is stored ANDed with (size-1) with bits 3:0 cleared.
- R7: With full detection and stop-on-full set, `msg_ready` stays low while (write offset + 16) mod size equals the read offset. A message is accepted once software advances the read offset.
- R8: With full detection set and stop-on-full clear, a message that arrives while the ring is full is accepted but discarded. No memory write occurs, the write offset is unchanged, and the overflow flag is set until it is cleared.
- R9: With full detection clear, logging continues past the read offset. After 2^(15+s)/16 messages from zero, the write offset is back to zero.
- R10: With enable clear, `msg_ready` is low and no memory write starts. With enable or interrupt enable clear, `irq` is low.
- R11: A new size select is stored at once but takes effect only in the cycle after both offsets are zero. Until then, read offset masking uses the previous size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on `reg_addr`) |
| msg_valid | input | 1 | Inbound message present |
| msg_data | input | 32 | Inbound message data word |
| msg_ready | output | 1 | Message accepted when high with `msg_valid` |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | 64 | Memory byte address of the record |
| mem_wdata | output | 128 | 16-byte record, byte 0 in bits 7:0 |
| mem_ack | input | 1 | Memory write acknowledge |
| irq | output | 1 | Level interrupt: unread records present |

## Verification
On every cycle, the assertions check the following. The write request and record stay stable until acknowledged. The write offset moves by exactly one wrapped record step per acknowledge. The read offset stays inside the active ring. The size changes only when both offsets are zero. A disabled block or a full ring with stop-on-full never raises `msg_ready`, and the interrupt is never high while it is gated off or the ring is empty. Only the directed scenarios can show the end-to-end effects. These are wrapping after a full ring of traffic, the drop-and-flag path and its clear, and the release of a held message after the read offset moves. They also cover overwriting past the read offset with full detection off and the deferred size change seen through masked read-offset writes.

// File: rtl/msi_ring_pkg.sv
package msi_ring_pkg;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 64;
    localparam int REG_W     = 32;
    localparam int REG_AW    = 3;
    localparam int REC_SHIFT = 4;
    localparam int REC_BYTES = 1 << REC_SHIFT;
    localparam int REC_W     = REC_BYTES * 8;
    localparam int MIN_SHIFT = 15;
    localparam int SEL_W     = 2;
    localparam int OFF_W     = MIN_SHIFT + (1 << SEL_W) - 1;

    localparam logic [REG_AW-1:0] RA_CTRL    = 3'd0;
    localparam logic [REG_AW-1:0] RA_BASE_HI = 3'd3;
    localparam logic [REG_AW-1:0] RA_BASE_LO = 3'd4;
    localparam logic [REG_AW-1:0] RA_RD_OFF  = 3'd5;
    localparam logic [REG_AW-1:0] RA_WR_OFF  = 3'd6;

    localparam int CB_EN    = 0;
    localparam int CB_FDET  = 1;
    localparam int CB_IRQEN = 3;
    localparam int CB_STOP  = 4;
    localparam int CB_SIZE  = 8;
    localparam int CB_OVF   = 16;

    typedef struct packed {
        logic             en;
        logic             full_det;
        logic             irq_en;
        logic             stop_full;
        logic [SEL_W-1:0] size_sel;
    } ctrl_t;

    function automatic logic [OFF_W-1:0] ring_mask(input logic [SEL_W-1:0] sel);
        return ((OFF_W'(1) << (MIN_SHIFT + int'(sel))) - OFF_W'(1)) & ~OFF_W'(REC_BYTES - 1);
    endfunction
endpackage

// File: rtl/msi_ring_regs.sv
module msi_ring_regs
    import msi_ring_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic [REG_W-1:0]     reg_wdata,
    input  logic [OFF_W-1:0]     wr_off,
    output ctrl_t                ctrl,
    output logic [SEL_W-1:0]     size_act,
    output logic [OFF_W-1:0]     mask,
    output logic [ADDR_W-1:0]    base,
    output logic [OFF_W-1:0]     rd_off,
    output logic                 ovf_clr,
    output logic                 wr_load
);
    typedef struct packed {
        ctrl_t             ctrl;
        logic [REG_W-1:0]  base_hi;
        logic [REG_W-1:0]  base_lo;
        logic [OFF_W-1:0]  rd;
        logic [SEL_W-1:0]  size;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        ovf_clr = 1'b0;
        wr_load = 1'b0;
        if (reg_we) begin
            case (reg_addr)
                RA_CTRL: begin
                    st_d.ctrl.en        = reg_wdata[CB_EN];
                    st_d.ctrl.full_det  = reg_wdata[CB_FDET];
                    st_d.ctrl.irq_en    = reg_wdata[CB_IRQEN];
                    st_d.ctrl.stop_full = reg_wdata[CB_STOP];
                    st_d.ctrl.size_sel  = reg_wdata[CB_SIZE +: SEL_W];
                    ovf_clr             = reg_wdata[CB_OVF];
                end
                RA_BASE_HI: st_d.base_hi = reg_wdata;
                RA_BASE_LO: st_d.base_lo = reg_wdata;
                RA_RD_OFF:  st_d.rd      = reg_wdata[OFF_W-1:0] & ring_mask(st_q.size);
                RA_WR_OFF:  wr_load      = 1'b1;
                default: ;
            endcase
        end
        // new ring size applies only once both offsets sit at zero
        if (st_q.rd == '0 && wr_off == '0) begin
            st_d.size = st_q.ctrl.size_sel;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl     = st_q.ctrl;
    assign size_act = st_q.size;
    assign mask     = ring_mask(st_q.size);
    assign base     = {st_q.base_hi, st_q.base_lo};
    assign rd_off   = st_q.rd;

    p_rd_in_ring_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_off & ~ring_mask(size_act)) == '0);

    p_size_defer_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (size_act != $past(size_act)) |-> ($past(rd_off) == '0 && $past(wr_off) == '0));
endmodule

// File: rtl/msi_ring_engine.sv
module msi_ring_engine
    import msi_ring_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  ctrl_t                ctrl,
    input  logic [OFF_W-1:0]     mask,
    input  logic [OFF_W-1:0]     rd_off,
    input  logic [ADDR_W-1:0]    base,
    input  logic                 wr_load,
    input  logic [OFF_W-1:0]     wr_wdata,
    input  logic                 ovf_clr,
    input  logic                 msg_valid,
    input  logic [DATA_W-1:0]    msg_data,
    output logic                 msg_ready,
    output logic                 mem_req,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [REC_W-1:0]     mem_wdata,
    input  logic                 mem_ack,
    output logic [OFF_W-1:0]     wr_off,
    output logic                 ovf
);
    typedef struct packed {
        logic              busy;
        logic [DATA_W-1:0] data;
        logic [OFF_W-1:0]  wr;
        logic              ovf;
    } eng_t;

    eng_t             en_d, en_q;
    logic [OFF_W-1:0] nxt_wr;
    logic             full;

    always_comb begin
        en_d      = en_q;
        msg_ready = 1'b0;
        nxt_wr    = (en_q.wr + OFF_W'(REC_BYTES)) & mask;
        full      = ctrl.full_det && (nxt_wr == rd_off);
        if (ovf_clr) en_d.ovf = 1'b0;
        if (en_q.busy) begin
            if (mem_ack) begin
                en_d.busy = 1'b0;
                en_d.wr   = nxt_wr;
            end
        end else if (wr_load) begin
            en_d.wr = wr_wdata & mask;
        end else if (ctrl.en && !(full && ctrl.stop_full)) begin
            msg_ready = 1'b1;
            if (msg_valid) begin
                if (full) begin
                    en_d.ovf = 1'b1;
                end else begin
                    en_d.busy = 1'b1;
                    en_d.data = msg_data;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    assign mem_req   = en_q.busy;
    assign mem_addr  = base + {{(ADDR_W-OFF_W){1'b0}}, en_q.wr};
    assign mem_wdata = {{(REC_W-DATA_W){1'b0}}, en_q.data};
    assign wr_off    = en_q.wr;
    assign ovf       = en_q.ovf;

    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_wdata) && $stable(wr_off)));

    p_one_outstanding_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !msg_ready);

    p_wr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> (wr_off == (($past(wr_off) + OFF_W'(REC_BYTES)) & $past(mask))));

    p_stop_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.full_det && ctrl.stop_full && ((wr_off + OFF_W'(REC_BYTES)) & mask) == rd_off)
        |-> !msg_ready);

    p_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.en |-> !msg_ready);
endmodule

// File: rtl/msi_ring_ctrl.sv
module msi_ring_ctrl
    import msi_ring_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    input  logic                 msg_valid,
    input  logic [DATA_W-1:0]    msg_data,
    output logic                 msg_ready,
    output logic                 mem_req,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [REC_W-1:0]     mem_wdata,
    input  logic                 mem_ack,
    output logic                 irq
);
    ctrl_t             ctrl;
    logic [SEL_W-1:0]  size_act;
    logic [OFF_W-1:0]  mask, rd_off, wr_off;
    logic [ADDR_W-1:0] base;
    logic              ovf_clr, wr_load, ovf;

    msi_ring_regs u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .wr_off(wr_off), .ctrl(ctrl), .size_act(size_act),
        .mask(mask), .base(base), .rd_off(rd_off), .ovf_clr(ovf_clr), .wr_load(wr_load)
    );

    msi_ring_engine u_engine (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .mask(mask), .rd_off(rd_off),
        .base(base), .wr_load(wr_load), .wr_wdata(reg_wdata[OFF_W-1:0]),
        .ovf_clr(ovf_clr), .msg_valid(msg_valid), .msg_data(msg_data),
        .msg_ready(msg_ready), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .wr_off(wr_off), .ovf(ovf)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_CTRL: begin
                reg_rdata[CB_EN]              = ctrl.en;
                reg_rdata[CB_FDET]            = ctrl.full_det;
                reg_rdata[CB_IRQEN]           = ctrl.irq_en;
                reg_rdata[CB_STOP]            = ctrl.stop_full;
                reg_rdata[CB_SIZE +: SEL_W]   = ctrl.size_sel;
                reg_rdata[CB_OVF]             = ovf;
            end
            RA_BASE_HI: reg_rdata = base[ADDR_W-1:REG_W];
            RA_BASE_LO: reg_rdata = base[REG_W-1:0];
            RA_RD_OFF:  reg_rdata = REG_W'(rd_off);
            RA_WR_OFF:  reg_rdata = REG_W'(wr_off);
            default:    reg_rdata = '0;
        endcase
    end

    assign irq = ctrl.en && ctrl.irq_en && (rd_off != wr_off);

    p_irq_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl.en && ctrl.irq_en) |-> !irq);

    p_irq_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_off == wr_off) |-> !irq);

    p_size_known_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(size_act));
endmodule

// File: tb/msi_ring_ctrl_test.sv
module msi_ring_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;
    localparam int RING0_RECS = 2048;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_we = 1'b0;
    logic [2:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         msg_valid = 1'b0;
    logic [31:0]  msg_data = '0;
    logic         msg_ready;
    logic         mem_req;
    logic [63:0]  mem_addr;
    logic [127:0] mem_wdata;
    logic         mem_ack = 1'b0;
    logic         irq;

    int checks = 0;
    int errors = 0;
    int wr_count = 0;
    int ack_delay = 0;
    int delay_cnt = 0;
    logic [63:0]  last_addr = '0;
    logic [127:0] last_data = '0;
    localparam logic [63:0] BASE = 64'h0000_0012_3400_0000;

    msi_ring_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msg_valid(msg_valid),
        .msg_data(msg_data), .msg_ready(msg_ready), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin : responder
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                if (delay_cnt < ack_delay) begin
                    delay_cnt++;
                end else begin
                    mem_ack   = 1'b1;
                    last_addr = mem_addr;
                    last_data = mem_wdata;
                    wr_count++;
                    delay_cnt = 0;
                end
            end
        end
    end

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", WATCHDOG);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic check(input string req, input string what, input logic [127:0] act,
                         input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic send(input logic [31:0] d);
        @(negedge clk);
        msg_valid = 1'b1; msg_data = d;
        while (!msg_ready) @(negedge clk);
        @(negedge clk);
        msg_valid = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic clean();
        reg_write(3'd0, 32'h0);
        settle();
        reg_write(3'd6, 32'h0);
        reg_write(3'd5, 32'h0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        reg_read(3'd0, v); check("R1", "ctrl after reset", 128'(v), 128'h0);
        reg_read(3'd5, v); check("R1", "rd off after reset", 128'(v), 128'h0);
        reg_read(3'd6, v); check("R1", "wr off after reset", 128'(v), 128'h0);
        check("R1", "irq after reset", 128'(irq), 128'h0);
        check("R1", "mem_req after reset", 128'(mem_req), 128'h0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        reg_write(3'd3, BASE[63:32]);
        reg_write(3'd4, BASE[31:0]);
        reg_read(3'd3, v); check("R2", "base high", 128'(v), 128'(BASE[63:32]));
        reg_read(3'd4, v); check("R2", "base low", 128'(v), 128'(BASE[31:0]));
        reg_write(3'd0, 32'h0000_021A);
        reg_read(3'd0, v); check("R2", "ctrl fields", 128'(v), 128'h21A);
        reg_write(3'd0, 32'h0);
    endtask

    task automatic t_capture();
        logic [31:0] v;
        int base_cnt;
        clean();
        reg_write(3'd0, 32'h9);
        base_cnt = wr_count;
        send(32'hCAFE_0123);
        settle();
        check("R3", "record address", 128'(last_addr), 128'(BASE));
        check("R3", "record data", last_data, 128'hCAFE_0123);
        reg_read(3'd6, v); check("R4", "wr off after one", 128'(v), 128'h10);
        check("R5", "irq with pending", 128'(irq), 128'h1);
        send(32'h0000_BEEF);
        settle();
        check("R3", "second address", 128'(last_addr), 128'(BASE + 64'h10));
        check("R3", "write count", 128'(wr_count - base_cnt), 128'd2);
        reg_write(3'd5, 32'h20);
        #1 check("R5", "irq after drain", 128'(irq), 128'h0);
        // slow acknowledge: request and record held
        ack_delay = 3;
        send(32'h1111_2222);
        #1 check("R3", "req raised", 128'(mem_req), 128'h1);
        check("R3", "held address", 128'(mem_addr), 128'(BASE + 64'h20));
        repeat (2) @(negedge clk);
        #1 check("R3", "req still held", 128'(mem_req), 128'h1);
        check("R3", "held data", mem_wdata, 128'h1111_2222);
        check("R3", "not ready while busy", 128'(msg_ready), 128'h0);
        settle();
        ack_delay = 0;
        reg_read(3'd6, v); check("R4", "wr off after slow ack", 128'(v), 128'h30);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        clean();
        reg_write(3'd5, 32'h0001_2345);
        reg_read(3'd5, v); check("R6", "masked read offset", 128'(v), 128'h2340);
    endtask

    task automatic t_disabled();
        int base_cnt;
        int bad;
        clean();
        reg_write(3'd0, 32'h9);
        send(32'h5);
        settle();
        reg_write(3'd0, 32'h0);
        #1 check("R10", "irq gated off", 128'(irq), 128'h0);
        base_cnt = wr_count;
        bad = 0;
        @(negedge clk);
        msg_valid = 1'b1; msg_data = 32'h77;
        repeat (6) begin
            @(negedge clk);
            if (msg_ready || mem_req) bad++;
        end
        msg_valid = 1'b0;
        check("R10", "ready/req while disabled", 128'(bad), 128'h0);
        check("R10", "no write while disabled", 128'(wr_count - base_cnt), 128'h0);
    endtask

    task automatic t_stop_full();
        logic [31:0] v;
        int base_cnt;
        int bad;
        clean();
        reg_write(3'd0, 32'h1B);
        for (int i = 0; i < RING0_RECS - 1; i++) send(32'(i));
        settle();
        reg_read(3'd6, v); check("R7", "wr off when full", 128'(v), 128'h7FF0);
        base_cnt = wr_count;
        bad = 0;
        @(negedge clk);
        msg_valid = 1'b1; msg_data = 32'hF00D;
        repeat (10) begin
            @(negedge clk);
            if (msg_ready) bad++;
        end
        check("R7", "held off when full", 128'(bad), 128'h0);
        check("R7", "no write when full", 128'(wr_count - base_cnt), 128'h0);
        reg_write(3'd5, 32'h10);
        while (!msg_ready) @(negedge clk);
        @(negedge clk);
        msg_valid = 1'b0;
        settle();
        check("R7", "released write", 128'(wr_count - base_cnt), 128'h1);
        check("R4", "last slot address", 128'(last_addr), 128'(BASE + 64'h7FF0));
        reg_read(3'd6, v); check("R4", "wr off wrapped", 128'(v), 128'h0);
    endtask

    task automatic t_drop();
        logic [31:0] v;
        int base_cnt;
        clean();
        reg_write(3'd0, 32'h3);
        for (int i = 0; i < RING0_RECS - 1; i++) send(32'(i));
        settle();
        base_cnt = wr_count;
        send(32'hDEAD);
        settle();
        check("R8", "dropped not written", 128'(wr_count - base_cnt), 128'h0);
        reg_read(3'd6, v); check("R8", "wr off unchanged", 128'(v), 128'h7FF0);
        reg_read(3'd0, v); check("R8", "overflow flag set", 128'(v), 128'h10003);
        reg_write(3'd0, 32'h10003);
        reg_read(3'd0, v); check("R8", "overflow cleared", 128'(v), 128'h3);
    endtask

    task automatic t_nodetect();
        logic [31:0] v;
        int base_cnt;
        clean();
        reg_write(3'd0, 32'h1);
        base_cnt = wr_count;
        for (int i = 0; i < RING0_RECS; i++) send(32'(i));
        settle();
        check("R9", "all written", 128'(wr_count - base_cnt), 128'(RING0_RECS));
        reg_read(3'd6, v); check("R9", "wr off back to zero", 128'(v), 128'h0);
    endtask

    task automatic t_size();
        logic [31:0] v;
        clean();
        reg_write(3'd0, 32'h1);
        send(32'h1);
        settle();
        reg_write(3'd0, 32'h101);
        reg_read(3'd0, v); check("R11", "size field stored", 128'(v), 128'h101);
        reg_write(3'd5, 32'h8000);
        reg_read(3'd5, v); check("R11", "old size still masks", 128'(v), 128'h0);
        reg_write(3'd6, 32'h0);
        @(negedge clk);
        reg_write(3'd5, 32'h8000);
        reg_read(3'd5, v); check("R11", "new size after zero", 128'(v), 128'h8000);
    endtask

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_capture();
        t_mask();
        t_disabled();
        t_stop_full();
        t_drop();
        t_nodetect();
        t_size();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule